// File: doc/BRIEF.md
# Sequential Tail Light Controller

This block drives the seven tail lamps across the rear of a vehicle. Lamp 1 is the leftmost and lamp 7 the rightmost. It takes four driver requests: turn left, turn right, brake and hazard. From these it produces a lamp pattern that moves forward one step for each pulse of a step enable. The system supplies that enable at three pulses per second, so each step lasts one third of a second. The lamp drivers and the enable generator sit outside the block.

A turn request sweeps a single lit lamp outward from the centre on the requested side. A hazard request ripples outward from the centre lamp toward both ends. Braking lights every lamp. Braking combined with a single turn keeps every lamp lit and instead sweeps one dark lamp outward on the turning side.

The requests are resolved in a fixed priority: brake first, then turn, then hazard. Whenever the resolved mode changes, the pattern starts again from its first step. The side width is a parameter; the default of three lamps per side gives the seven-lamp arrangement.

Top module: `tail_light_ctrl`

## Requirements
- R1: Reset is synchronous and active low. While `rst_n` is low at a clock edge, and after that edge, `lamps` is all zero. Bit `lamps[n-1]` drives lamp n, for n from 1 to 7.
- R2: With no request asserted, all lamps are dark (`lamps` = 0).
- R3: With only right turn, exactly one lamp is lit. Step 0 lights lamp 5, step 1 lights lamp 6 and step 2 lights lamp 7. The sequence then returns to step 0.
- R4: With only left turn, exactly one lamp is lit. Step 0 lights lamp 3, step 1 lights lamp 2 and step 2 lights lamp 1. The sequence then returns to step 0.
- R5: With hazard alone, the pattern has four steps and then repeats: lamp 4, then lamps 3 and 5, then lamps 2 and 6, then lamps 1 and 7.
- R6: Left and right turn asserted together, without brake, produce the R5 hazard pattern whatever the hazard input is.
- R7: Brake alone, brake with hazard, and brake with both turns all light all seven lamps. In these modes, step pulses change nothing.
- R8: Brake with exactly one turn keeps six lamps lit and one lamp dark. For right, the dark lamp is 5, then 6, then 7. For left, it is 3, then 2, then 1. The dark lamp advances one position per step and then repeats.
- R9: A single turn request takes priority over hazard. Hazard with one turn shows that turn's pattern (R3 or R4).
- R10: The inputs are sampled at a clock edge, and the pattern they select appears after that edge. When the resolved mode changes, the pattern restarts at step 0, even if `step_en` is high at the same edge.
- R11: The step advances only at a clock edge where `step_en` is high and the mode is unchanged. Otherwise `lamps` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | One-cycle pulse that advances the pattern one step |
| turn_left | input | 1 | Left turn request |
| turn_right | input | 1 | Right turn request |
| brake | input | 1 | Brake request |
| hazard | input | 1 | Hazard request |
| lamps | output | 7 | Lamp drive; bit n-1 drives lamp n, counted from the left |

## Verification
A mode change and a step pulse can fall on the same clock edge, and the restart must win. The bench provokes this with right turn at its third step: on a single edge it drops right, raises left and pulses `step_en`. It expects lamp 3, the first left step, rather than an advanced position. A second case releases brake while a brake-with-turn sweep is mid-sequence; the plain turn sweep must then begin again at lamp 5. Every other request combination is applied after an idle gap. The bench then counts step pulses and checks each result against a pattern computed from shifts of the step number.

// File: rtl/tl_pkg.sv
// Package: shared types for the tail light controller.
// Assumes at most eight resolved modes; encoding values are internal only.
package tl_pkg;

    typedef enum logic [2:0] {
        MODE_DARK        = 3'd0,
        MODE_LEFT        = 3'd1,
        MODE_RIGHT       = 3'd2,
        MODE_RIPPLE      = 3'd3,
        MODE_BRAKE       = 3'd4,
        MODE_BRAKE_LEFT  = 3'd5,
        MODE_BRAKE_RIGHT = 3'd6
    } tl_mode_e;

endpackage

// File: rtl/tl_mode_decode.sv
// Module: tl_mode_decode
// Resolves the four driver requests into one mode. The priority is brake,
// then a single turn, then hazard. Both turns together count as a hazard
// request. Purely combinational; the inputs are assumed synchronous to clk.
module tl_mode_decode
    import tl_pkg::*;
(
    input  logic     req_left,
    input  logic     req_right,
    input  logic     req_brake,
    input  logic     req_hazard,
    output tl_mode_e mode
);

    logic one_turn;
    logic both_turns;

    // Classify the turn inputs.
    always_comb begin
        one_turn   = req_left ^ req_right;
        both_turns = req_left & req_right;
    end

    // Apply the fixed request priority.
    always_comb begin
        if (req_brake) begin
            if (one_turn) begin
                mode = req_left ? MODE_BRAKE_LEFT : MODE_BRAKE_RIGHT;
            end else begin
                mode = MODE_BRAKE;
            end
        end else if (one_turn) begin
            mode = req_left ? MODE_LEFT : MODE_RIGHT;
        end else if (both_turns || req_hazard) begin
            mode = MODE_RIPPLE;
        end else begin
            mode = MODE_DARK;
        end
    end

endmodule

// File: rtl/tl_step_seq.sv
// Module: tl_step_seq
// Registers the resolved mode and keeps the step counter for the current
// pattern. A mode change forces step 0 and overrides a step pulse on the
// same edge. Sweeps last SIDE steps and the ripple lasts SIDE+1 steps.
// Steady modes stay at step 0. Reset is synchronous and active low.
module tl_step_seq
    import tl_pkg::*;
#(
    parameter int SIDE   = 3,
    parameter int STEP_W = $clog2(SIDE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  tl_mode_e          mode_next,
    output tl_mode_e          mode_q,
    output logic [STEP_W-1:0] step_q
);

    localparam logic [STEP_W-1:0] SWEEP_LAST  = STEP_W'(SIDE - 1);
    localparam logic [STEP_W-1:0] RIPPLE_LAST = STEP_W'(SIDE);

    logic [STEP_W-1:0] last_step;
    logic              mode_change;

    // Select the final step index of the active pattern.
    always_comb begin
        case (mode_q)
            MODE_LEFT, MODE_RIGHT,
            MODE_BRAKE_LEFT, MODE_BRAKE_RIGHT: last_step = SWEEP_LAST;
            MODE_RIPPLE:                       last_step = RIPPLE_LAST;
            default:                           last_step = '0;
        endcase
        mode_change = (mode_next != mode_q);
    end

    // Hold the active mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_DARK;
        end else begin
            mode_q <= mode_next;
        end
    end

    // Advance, wrap or restart the step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (mode_change) begin
            step_q <= '0;
        end else if (step_en) begin
            step_q <= (step_q == last_step) ? '0 : step_q + 1'b1;
        end
    end

    // R10: a new mode always starts at its first step.
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != $past(mode_q)) |-> (step_q == '0));

    // R11: without a step pulse the step index holds.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step_en) && mode_q == $past(mode_q)) |-> $stable(step_q));

    // R3: the step never passes the end of its pattern.
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        step_q <= last_step);

endmodule

// File: rtl/tl_lamp_map.sv
// Module: tl_lamp_map
// Maps the mode and step to the lamp vector. Lamp index SIDE is the centre.
// Left sweeps move toward index 0 and right sweeps toward index 2*SIDE.
// One slice per lamp is generated from its distance to the centre.
// Purely combinational.
module tl_lamp_map
    import tl_pkg::*;
#(
    parameter int SIDE   = 3,
    parameter int STEP_W = $clog2(SIDE + 1),
    parameter int NUM    = 2 * SIDE + 1
) (
    input  tl_mode_e          mode,
    input  logic [STEP_W-1:0] step,
    output logic [NUM-1:0]    lamps
);

    for (genvar i = 0; i < NUM; i++) begin : g_lamp
        localparam int DIST = (i >= SIDE) ? (i - SIDE) : (SIDE - i);
        logic at_ripple;
        logic at_left;
        logic at_right;

        // Decide whether the moving position covers this lamp.
        always_comb begin
            at_ripple = (step == STEP_W'(DIST));
            at_left   = (i < SIDE) && (step == STEP_W'(DIST - 1));
            at_right  = (i > SIDE) && (step == STEP_W'(DIST - 1));
        end

        // Drive this lamp for the active mode.
        always_comb begin
            case (mode)
                MODE_LEFT:        lamps[i] = at_left;
                MODE_RIGHT:       lamps[i] = at_right;
                MODE_RIPPLE:      lamps[i] = at_ripple;
                MODE_BRAKE:       lamps[i] = 1'b1;
                MODE_BRAKE_LEFT:  lamps[i] = !at_left;
                MODE_BRAKE_RIGHT: lamps[i] = !at_right;
                default:          lamps[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/tail_light_ctrl.sv
// Module: tail_light_ctrl
// Top of the tail light controller. Decodes the requests, sequences the
// steps and maps them to lamps. The inputs are assumed synchronous to clk,
// and step_en is assumed to be a single-cycle pulse at the step rate.
// The lamps follow the registered mode and step, one edge after sampling.
module tail_light_ctrl
    import tl_pkg::*;
#(
    parameter int LAMPS_PER_SIDE = 3,
    localparam int NUM_LAMPS     = 2 * LAMPS_PER_SIDE + 1,
    localparam int STEP_W        = $clog2(LAMPS_PER_SIDE + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic                 turn_left,
    input  logic                 turn_right,
    input  logic                 brake,
    input  logic                 hazard,
    output logic [NUM_LAMPS-1:0] lamps
);

    tl_mode_e          mode_next;
    tl_mode_e          mode_q;
    logic [STEP_W-1:0] step_q;

    tl_mode_decode u_decode (
        .req_left   (turn_left),
        .req_right  (turn_right),
        .req_brake  (brake),
        .req_hazard (hazard),
        .mode       (mode_next)
    );

    tl_step_seq #(
        .SIDE   (LAMPS_PER_SIDE),
        .STEP_W (STEP_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .mode_next (mode_next),
        .mode_q    (mode_q),
        .step_q    (step_q)
    );

    tl_lamp_map #(
        .SIDE   (LAMPS_PER_SIDE),
        .STEP_W (STEP_W),
        .NUM    (NUM_LAMPS)
    ) u_map (
        .mode  (mode_q),
        .step  (step_q),
        .lamps (lamps)
    );

    // R2: the idle mode leaves every lamp dark.
    a_r2_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DARK) |-> (lamps == '0));

    // R7: plain braking lights every lamp.
    a_r7_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BRAKE) |-> (&lamps));

    // R3 / R4: a plain turn shows exactly one lamp.
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LEFT || mode_q == MODE_RIGHT) |-> ($countones(lamps) == 1));

    // R8: braking with a turn darkens exactly one lamp.
    a_r8_one_out: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BRAKE_LEFT || mode_q == MODE_BRAKE_RIGHT)
        |-> ($countones(lamps) == NUM_LAMPS - 1));

    // R5: the ripple shows one or two lamps, with the centre lamp only at step 0.
    a_r5_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RIPPLE)
        |-> (($countones(lamps) == 1) == (step_q == '0)) && ($countones(lamps) <= 2));

endmodule

// File: tb/tail_light_ctrl_tb.sv
`timescale 1ns/1ps
module tail_light_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       step_en;
    logic       turn_left;
    logic       turn_right;
    logic       brake;
    logic       hazard;
    logic [6:0] lamps;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tail_light_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .turn_left  (turn_left),
        .turn_right (turn_right),
        .brake      (brake),
        .hazard     (hazard),
        .lamps      (lamps)
    );

    // Bench modes: 0 dark, 1 left, 2 right, 3 ripple, 4 brake, 5 brake-left, 6 brake-right.
    function automatic int mode_of(bit l, bit r, bit s, bit f);
        if (s) return (l ^ r) ? (l ? 5 : 6) : 4;
        if (l ^ r) return l ? 1 : 2;
        if ((l & r) | f) return 3;
        return 0;
    endfunction

    function automatic int period_of(int m);
        case (m)
            1, 2, 5, 6: return 3;
            3:          return 4;
            default:    return 1;
        endcase
    endfunction

    // Expected lamp vector; bit n-1 is lamp n.
    function automatic logic [6:0] expect_of(int m, int k);
        case (m)
            1: return 7'(1 << (2 - k));
            2: return 7'(1 << (4 + k));
            3: return 7'((1 << (3 - k)) | (1 << (3 + k)));
            4: return 7'h7F;
            5: return 7'h7F & ~7'(1 << (2 - k));
            6: return 7'h7F & ~7'(1 << (4 + k));
            default: return 7'h00;
        endcase
    endfunction

    function automatic string tag_of(bit l, bit r, bit s, bit f);
        int m = mode_of(l, r, s, f);
        case (m)
            0: return "R2";
            1, 2: return f ? "R9" : (l ? "R4" : "R3");
            3: return (l & r) ? "R6" : "R5";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [6:0] exp);
        checks++;
        if (lamps !== exp) begin
            errors++;
            $display("FAIL %s: lamps=%b expected=%b", req, lamps, exp);
        end
    endtask

    task automatic set_req(bit l, bit r, bit s, bit f);
        @(negedge clk);
        turn_left  = l;
        turn_right = r;
        brake      = s;
        hazard     = f;
        @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
    endtask

    initial begin
        #(5ns * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: lamps=%b expected=completion", lamps);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        step_en = 1'b0;
        turn_left = 1'b0;
        turn_right = 1'b0;
        brake = 1'b1;
        hazard = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 7'h00);
        rst_n = 1'b1;
        brake = 1'b0;
        @(negedge clk);
        check("R2", 7'h00);

        // Sweep every request combination through a full set of steps.
        for (int c = 0; c < 16; c++) begin
            bit l = c[0];
            bit r = c[1];
            bit f = c[2];
            bit s = c[3];
            int m = mode_of(l, r, s, f);
            set_req(1'b0, 1'b0, 1'b0, 1'b0);
            check("R2", 7'h00);
            set_req(l, r, s, f);
            check(tag_of(l, r, s, f), expect_of(m, 0));
            for (int p = 1; p <= 8; p++) begin
                pulse();
                check(tag_of(l, r, s, f), expect_of(m, p % period_of(m)));
            end
            repeat (3) @(negedge clk);
            check("R11", expect_of(m, 8 % period_of(m)));
        end

        // R10: a mode change on the same edge as a step pulse restarts the pattern.
        set_req(1'b0, 1'b0, 1'b0, 1'b0);
        set_req(1'b0, 1'b1, 1'b0, 1'b0);
        pulse();
        pulse();
        check("R3", 7'b1000000);
        @(negedge clk);
        turn_left = 1'b1;
        turn_right = 1'b0;
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check("R10", 7'b0000100);

        // R10: releasing brake mid-sweep restarts the plain turn sweep.
        set_req(1'b0, 1'b1, 1'b1, 1'b0);
        pulse();
        check("R8", 7'b1011111);
        set_req(1'b0, 1'b1, 1'b0, 1'b0);
        check("R10", 7'b0010000);

        // R11: a step pulse during reset is ignored and the lamps clear.
        @(negedge clk);
        rst_n = 1'b0;
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check("R1", 7'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3", 7'b0010000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule